// File: doc/BRIEF.md
# Two-Beat Coprocessor Load/Store Sequencer

This block sits between a 32-bit memory data bus and a bank of 64-bit coprocessor registers. It steers data during coprocessor load and store instructions. Each accepted bus beat is presented on `req`. The block decodes the instruction word and produces four things: per-half write enables and write data for the register bank, the word to drive onto the bus for a store, and a response telling the core whether another beat follows (INCREMENT) or the transfer is complete (DONE).

The register bank is outside the block. It reads the destination register addressed by `reg_idx` and returns its contents on `reg_rdata`, and it writes each 32-bit half under its own enable. A one-bit beat counter remembers whether the first word of a two-word transfer has already moved. All outputs follow the inputs combinationally within the cycle. Only the beat counter is clocked.

Top module: `cp_ldst_seq`

## Requirements
- R1: `instr[22]`=1 selects a two-word transfer and `instr[22]`=0 a one-word transfer. A one-word transfer answers DONE (`rsp_inc`=0) on its only beat. While `req`=0 no write enable is raised, `rsp_inc` is 0 and `mem_wdata` is 0.
- R2: A beat with `req`=1 and `is_data`=0 answers DONE, raises no write enable, drives `mem_wdata`=0 and returns the beat counter to zero. The next two-word data beat is therefore treated as a first beat.
- R3: When `big_end`=1, a two-word transfer moves the upper half (bits 63:32) on its first beat and the lower half on its second. A load enables only that half and a store drives only that half.
- R4: When `big_end`=0, a two-word transfer moves the lower half on its first beat and the upper half on its second.
- R5: In a two-word transfer the first data beat answers INCREMENT (`rsp_inc`=1) and the second answers DONE (`rsp_inc`=0).
- R6: `instr[8]`=0 selects the float class. A one-word float load writes the bus word into the upper half, and a one-word float store drives the upper half onto the bus. `instr[20]`=1 marks a load and 0 a store.
- R7: `instr[8]`=1 selects the integer class. A one-word integer load writes both halves with the bus word sign-extended to 64 bits.
- R8: A one-word integer store drives the lower half of the register onto the bus.
- R9: `reg_idx` equals `instr[15:12]`.
- R10: A one-word float load keeps `wr_lo_en` low, so the lower half of the destination is left unchanged.
- R11: The beat counter is zero after reset and after the DONE beat of a two-word transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | A bus cycle is presented this clock |
| is_data | input | 1 | The presented cycle is a data cycle |
| big_end | input | 1 | 1 = big-endian word order |
| instr | input | 32 | Coprocessor load/store instruction word |
| mem_rdata | input | 32 | Word from memory for a load |
| reg_rdata | input | 64 | Current contents of the destination register |
| reg_idx | output | 4 | Destination register index |
| wr_hi_en | output | 1 | Write the upper half |
| wr_lo_en | output | 1 | Write the lower half |
| wr_data | output | 64 | Register write data |
| mem_wdata | output | 32 | Word for memory on a store |
| rsp_inc | output | 1 | 1 = INCREMENT, 0 = DONE |

## Verification
The bench runs two-word transfers in both word orders and both directions. A swapped endianness decode would write or send the wrong half on each beat. A bus cycle that is not a data cycle is inserted in the middle of a transfer. A counter that ignored it would treat the following beat as a second beat and answer DONE too early. The bench also applies a reset between the two beats of a transfer, which catches a counter that survives reset. For one-word loads it checks that negative words fill the upper half with ones and positive words with zeros, and that a float load leaves the lower half unwritten. An extension done on the wrong class, or a stray lower-half enable, would corrupt the register.

// File: rtl/cp_ldst_seq.sv
module cp_ldst_seq #(
  parameter int WORD_W    = 32,
  parameter int IDX_W     = 4,
  parameter int INSTR_W   = 32,
  parameter int LONG_BIT  = 22,
  parameter int LOAD_BIT  = 20,
  parameter int CLASS_BIT = 8,
  parameter int IDX_LSB   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  is_data,
  input  logic                  big_end,
  input  logic [INSTR_W-1:0]    instr,
  input  logic [WORD_W-1:0]     mem_rdata,
  input  logic [2*WORD_W-1:0]   reg_rdata,
  output logic [IDX_W-1:0]      reg_idx,
  output logic                  wr_hi_en,
  output logic                  wr_lo_en,
  output logic [2*WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]     mem_wdata,
  output logic                  rsp_inc
);
  localparam int REG_W = 2 * WORD_W;

  logic beat;
  logic active, long_acc, is_load, int_cls, pick_hi, sext_case;
  logic [WORD_W-1:0] hi_half, lo_half;

  assign active    = req && is_data;
  assign long_acc  = instr[LONG_BIT];
  assign is_load   = instr[LOAD_BIT];
  assign int_cls   = instr[CLASS_BIT];
  assign sext_case = !long_acc && int_cls;
  assign pick_hi   = long_acc ? (beat ^ big_end) : !int_cls;

  assign hi_half = reg_rdata[REG_W-1:WORD_W];
  assign lo_half = reg_rdata[WORD_W-1:0];

  assign reg_idx  = instr[IDX_LSB +: IDX_W];
  assign wr_hi_en = active && is_load && (pick_hi || sext_case);
  assign wr_lo_en = active && is_load && !pick_hi;
  assign wr_data  = sext_case ? {{WORD_W{mem_rdata[WORD_W-1]}}, mem_rdata}
                              : {mem_rdata, mem_rdata};
  assign mem_wdata = (active && !is_load) ? (pick_hi ? hi_half : lo_half)
                                          : '0;
  assign rsp_inc  = active && long_acc && !beat;

  always_ff @(posedge clk) begin
    if (!rst_n)   beat <= 1'b0;
    else if (req) beat <= active && long_acc && !beat;
  end
endmodule

module cp_ldst_seq_chk #(
  parameter int INSTR_W   = 32,
  parameter int LONG_BIT  = 22,
  parameter int LOAD_BIT  = 20,
  parameter int CLASS_BIT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req,
  input logic               is_data,
  input logic [INSTR_W-1:0] instr,
  input logic               wr_hi_en,
  input logic               wr_lo_en,
  input logic               rsp_inc,
  input logic               beat
);
  p_short_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_data && !instr[LONG_BIT]) |-> !rsp_inc);

  p_nondata_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_data) |-> (!rsp_inc && !wr_hi_en && !wr_lo_en));

  p_nondata_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !is_data) |=> !beat);

  p_long_one_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_data && instr[LOAD_BIT] && instr[LONG_BIT])
      |-> ($countones({wr_hi_en, wr_lo_en}) == 1));

  p_inc_advances_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_data && instr[LONG_BIT] && rsp_inc) |=> beat);

  p_float_keep_lo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_data && instr[LOAD_BIT] && !instr[LONG_BIT] && !instr[CLASS_BIT])
      |-> (wr_hi_en && !wr_lo_en));

  p_done_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_data && instr[LONG_BIT] && !rsp_inc) |=> !beat);
endmodule

bind cp_ldst_seq cp_ldst_seq_chk #(
  .INSTR_W(INSTR_W), .LONG_BIT(LONG_BIT), .LOAD_BIT(LOAD_BIT), .CLASS_BIT(CLASS_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .is_data(is_data), .instr(instr),
  .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en), .rsp_inc(rsp_inc), .beat(beat)
);

// File: tb/sim_cp_ldst_seq.sv
module sim_cp_ldst_seq;
  logic clk = 1'b0;
  logic rst_n, req, is_data, big_end;
  logic [31:0] instr, mem_rdata, mem_wdata;
  logic [63:0] reg_rdata, wr_data;
  logic [3:0]  reg_idx;
  logic wr_hi_en, wr_lo_en, rsp_inc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cp_ldst_seq u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .is_data(is_data), .big_end(big_end),
    .instr(instr), .mem_rdata(mem_rdata), .reg_rdata(reg_rdata),
    .reg_idx(reg_idx), .wr_hi_en(wr_hi_en), .wr_lo_en(wr_lo_en),
    .wr_data(wr_data), .mem_wdata(mem_wdata), .rsp_inc(rsp_inc)
  );

  localparam logic [31:0] A  = 32'h89AB_CDEF;
  localparam logic [31:0] B  = 32'h1234_5678;
  localparam logic [63:0] RG = 64'hDEAD_BEEF_0BAD_F00D;
  localparam logic [31:0] RH = 32'hDEAD_BEEF;
  localparam logic [31:0] RL = 32'h0BAD_F00D;

  typedef struct packed {
    logic        lng;
    logic        ld;
    logic        ic;
    logic [3:0]  idx;
    logic        dat;
    logic        big;
    logic [31:0] mem;
    logic [63:0] rd;
    logic        ehi;
    logic        elo;
    logic [63:0] ewr;
    logic [31:0] est;
    logic        ersp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b1,1'b0,4'd3, 1'b1,1'b1,A,RG,1'b1,1'b0,{A,A},32'h0,1'b1},
    '{1'b1,1'b1,1'b0,4'd3, 1'b1,1'b1,B,RG,1'b0,1'b1,{B,B},32'h0,1'b0},
    '{1'b1,1'b1,1'b0,4'd7, 1'b1,1'b0,B,RG,1'b0,1'b1,{B,B},32'h0,1'b1},
    '{1'b1,1'b1,1'b0,4'd7, 1'b1,1'b0,A,RG,1'b1,1'b0,{A,A},32'h0,1'b0},
    '{1'b1,1'b0,1'b0,4'd9, 1'b1,1'b1,A,RG,1'b0,1'b0,64'h0,RH,1'b1},
    '{1'b1,1'b0,1'b0,4'd9, 1'b1,1'b1,A,RG,1'b0,1'b0,64'h0,RL,1'b0},
    '{1'b1,1'b0,1'b1,4'd15,1'b1,1'b0,A,RG,1'b0,1'b0,64'h0,RL,1'b1},
    '{1'b1,1'b0,1'b1,4'd15,1'b1,1'b0,A,RG,1'b0,1'b0,64'h0,RH,1'b0},
    '{1'b0,1'b1,1'b0,4'd1, 1'b1,1'b1,A,RG,1'b1,1'b0,{A,A},32'h0,1'b0},
    '{1'b0,1'b1,1'b1,4'd2, 1'b1,1'b0,A,RG,1'b1,1'b1,{32'hFFFF_FFFF,A},32'h0,1'b0},
    '{1'b0,1'b1,1'b1,4'd2, 1'b1,1'b1,B,RG,1'b1,1'b1,{32'h0,B},32'h0,1'b0},
    '{1'b0,1'b0,1'b0,4'd4, 1'b1,1'b0,A,RG,1'b0,1'b0,64'h0,RH,1'b0},
    '{1'b0,1'b0,1'b1,4'd5, 1'b1,1'b1,A,RG,1'b0,1'b0,64'h0,RL,1'b0},
    '{1'b1,1'b1,1'b1,4'd6, 1'b1,1'b1,A,RG,1'b1,1'b0,{A,A},32'h0,1'b1},
    '{1'b1,1'b1,1'b1,4'd6, 1'b0,1'b1,A,RG,1'b0,1'b0,64'h0,32'h0,1'b0},
    '{1'b1,1'b1,1'b1,4'd6, 1'b1,1'b1,B,RG,1'b1,1'b0,{B,B},32'h0,1'b1},
    '{1'b1,1'b1,1'b1,4'd6, 1'b1,1'b1,A,RG,1'b0,1'b1,{A,A},32'h0,1'b0}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 1:          return "R3";
      2, 3:          return "R4";
      4, 5:          return "R3";
      6, 7:          return "R4";
      8:             return "R10";
      9, 10:         return "R7";
      11:            return "R6";
      12:            return "R8";
      14:            return "R2";
      15:            return "R2";
      default:       return "R5";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  function automatic logic [31:0] mk_instr(logic lng, logic ld, logic ic, logic [3:0] idx);
    logic [31:0] w;
    w = 32'h0000_0400;
    w[22] = lng;
    w[20] = ld;
    w[8]  = ic;
    w[15:12] = idx;
    return w;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; is_data = 1'b0; big_end = 1'b0;
    instr = 32'h0; mem_rdata = 32'h0; reg_rdata = RG;
    repeat (2) @(negedge clk);
    #1;
    chk("R11 reset rsp", {63'h0, rsp_inc}, 64'h0);
    chk("R1 reset en", {62'h0, wr_hi_en, wr_lo_en}, 64'h0);
    chk("R1 reset st", {32'h0, mem_wdata}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      req = 1'b1;
      is_data = TBL[i].dat;
      big_end = TBL[i].big;
      instr = mk_instr(TBL[i].lng, TBL[i].ld, TBL[i].ic, TBL[i].idx);
      mem_rdata = TBL[i].mem;
      reg_rdata = TBL[i].rd;
      #1;
      chk({tag_of(i), " en"}, {62'h0, wr_hi_en, wr_lo_en}, {62'h0, TBL[i].ehi, TBL[i].elo});
      chk("R5 rsp", {63'h0, rsp_inc}, {63'h0, TBL[i].ersp});
      chk({tag_of(i), " st"}, {32'h0, mem_wdata}, {32'h0, TBL[i].est});
      chk("R9 idx", {60'h0, reg_idx}, {60'h0, TBL[i].idx});
      if (TBL[i].ld && TBL[i].dat) chk({tag_of(i), " wr"}, wr_data, TBL[i].ewr);
    end

    @(negedge clk);
    req = 1'b0; is_data = 1'b1; big_end = 1'b1;
    instr = mk_instr(1'b1, 1'b1, 1'b0, 4'd3);
    #1;
    chk("R1 idle en", {62'h0, wr_hi_en, wr_lo_en}, 64'h0);
    chk("R1 idle rsp", {63'h0, rsp_inc}, 64'h0);

    @(negedge clk);
    req = 1'b1;
    #1;
    chk("R11 first beat rsp", {63'h0, rsp_inc}, 64'h1);
    @(negedge clk);
    req = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1; req = 1'b1;
    #1;
    chk("R11 after reset en", {62'h0, wr_hi_en, wr_lo_en}, 64'h2);
    chk("R11 after reset rsp", {63'h0, rsp_inc}, 64'h1);
    @(negedge clk);
    #1;
    chk("R5 second rsp", {63'h0, rsp_inc}, 64'h0);
    @(negedge clk);
    instr = mk_instr(1'b0, 1'b1, 1'b1, 4'd8);
    #1;
    chk("R1 short rsp", {63'h0, rsp_inc}, 64'h0);
    @(negedge clk);
    req = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule